// File: doc/BRIEF.md
# Opcode Operand Sequencer

This block hands the operands of the opcode now executing to the execution side, one item for each read strobe. When an opcode is dispatched, its decoded attributes are captured: its kind (regular, pause or jump), its byte length, a sign flag, a packed flag, a 4-bit N field and the operand bytes a and b. From then on, each read returns the next item of a sequence that depends on those attributes. Once the operands run out, every further read returns the opcode length, which the execution side uses for fall-through arithmetic.

Jump opcodes spend their operands on the displacement calculation, so reads during a jump return only the length. A saturating 3-bit count of reads since dispatch is visible on a status port. A one-cycle error pulse reports a dispatch that ends a 3-byte opcode whose operand a was never fully read in an earlier cycle. Shorter opcodes may be left without reading any of their operands.

Top module: `opseq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `rd_valid`, `rd_count` and `dsp_err` are 0. A read made before any dispatch returns the value 0.
- R2: A dispatch (`dispatch`=1) captures all opcode inputs on that clock edge and sets `rd_count` to 0. The opcode inputs may then change with no effect. A read strobe in the same cycle as a dispatch is ignored: it produces no item and does not count.
- R3: Each read strobe outside a dispatch cycle produces exactly one item. `rd_data` holds the item and `rd_valid` is 1 on the cycle after the strobe. `rd_valid` is 0 in every other cycle.
- R4: For a regular opcode (`op_kind`=00, or the reserved code 11), the first item is N, zero-extended, but only when N is not 15. When N is 15, N is skipped.
- R5: For lengths 2 and 3, operand a comes after N. For length 3, operand b comes after a, zero-extended.
- R6: When the packed flag is 1, a is delivered as two zero-extended items: first a[7:4], then a[3:0]. The sign flag is then ignored.
- R7: When the packed flag is 0, a is sign-extended to `OUT_W` bits if the sign flag is 1, and zero-extended if it is 0.
- R8: Once the operands are exhausted, every further read returns the opcode length, zero-extended, with no limit. For length 1, the only operand is N.
- R9: For a jump opcode (`op_kind`=10), every read returns the length.
- R10: A pause opcode (`op_kind`=01) produces exactly the same item sequence as a regular opcode with the same fields.
- R11: `rd_count` rises by one for each counted read and stays at 7 once it reaches 7.
- R12: `dsp_err` pulses for one cycle, on the cycle after a dispatch, when the opcode being replaced was a non-jump of length 3 and its operand a was not fully read (both nibbles if packed) by an earlier read. The pulse does not occur for any other opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dispatch | input | 1 | Start of the next opcode; captures the op_* inputs |
| op_kind | input | 2 | 00 regular, 01 pause, 10 jump, 11 treated as regular |
| op_len | input | 2 | Opcode length in bytes (1 to 3) |
| op_sign | input | 1 | Sign-extend unpacked a |
| op_packed | input | 1 | Deliver a as two nibbles |
| op_n | input | 4 | N operand; 15 means absent |
| op_a | input | 8 | First operand byte |
| op_b | input | 8 | Second operand byte |
| rd | input | 1 | Read strobe for the next item |
| rd_data | output | OUT_W | Item returned by the last read |
| rd_valid | output | 1 | rd_data holds a new item this cycle |
| rd_count | output | CNT_W | Saturating count of reads since dispatch |
| dsp_err | output | 1 | Early-dispatch error pulse |

## Verification
Every result is registered once. An item, its `rd_valid` flag and the new `rd_count` appear on the cycle after the read strobe. The error pulse and the cleared count appear on the cycle after the dispatch edge. The bench drives inputs on falling edges and samples 5 ns after each rising edge. The monitor pops a queued expectation each time `rd_valid` is seen, so it checks an item in the one cycle where it is due. After each burst of reads, the bench confirms that the queue has drained and that the count shows the reads made.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  typedef enum logic [2:0] {
    STP_N   = 3'd0,
    STP_AHI = 3'd1,
    STP_ALO = 3'd2,
    STP_A   = 3'd3,
    STP_B   = 3'd4,
    STP_LEN = 3'd5
  } step_t;

  localparam logic [1:0] KIND_JUMP = 2'b10;
  localparam logic [3:0] N_ABSENT  = 4'hF;
  localparam logic [1:0] LEN_LONG  = 2'd3;
endpackage

// File: rtl/opseq_step.sv
module opseq_step
  import opseq_pkg::*;
(
  input  logic       restart,
  input  logic       is_jump,
  input  logic       packed_a,
  input  logic [1:0] len,
  input  logic [3:0] n,
  input  step_t      cur,
  output step_t      nxt
);
  step_t after_n;
  step_t after_a;

  always_comb begin
    after_a = (len == LEN_LONG) ? STP_B : STP_LEN;
    if (len >= 2'd2) after_n = packed_a ? STP_AHI : STP_A;
    else             after_n = STP_LEN;

    if (restart) begin
      if (is_jump)             nxt = STP_LEN;
      else if (n != N_ABSENT)  nxt = STP_N;
      else                     nxt = after_n;
    end else begin
      case (cur)
        STP_N:          nxt = after_n;
        STP_AHI:        nxt = STP_ALO;
        STP_ALO, STP_A: nxt = after_a;
        default:        nxt = STP_LEN;
      endcase
    end
  end
endmodule

// File: rtl/opseq_item_mux.sv
module opseq_item_mux
  import opseq_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  step_t             step,
  input  logic              sign_a,
  input  logic [1:0]        len,
  input  logic [3:0]        n,
  input  logic [7:0]        a,
  input  logic [7:0]        b,
  output logic [OUT_W-1:0]  item
);
  localparam int EXT_W = OUT_W - 8;
  localparam int NIB_W = OUT_W - 4;
  localparam int LEN_W = OUT_W - 2;

  logic [OUT_W-1:0] a_ext;

  always_comb begin
    a_ext = sign_a ? {{EXT_W{a[7]}}, a} : {{EXT_W{1'b0}}, a};
    case (step)
      STP_N:   item = {{NIB_W{1'b0}}, n};
      STP_AHI: item = {{NIB_W{1'b0}}, a[7:4]};
      STP_ALO: item = {{NIB_W{1'b0}}, a[3:0]};
      STP_A:   item = a_ext;
      STP_B:   item = {{EXT_W{1'b0}}, b};
      default: item = {{LEN_W{1'b0}}, len};
    endcase
  end
endmodule

// File: rtl/opseq_rdcnt.sv
module opseq_rdcnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)                  cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/opseq_top.sv
module opseq_top
  import opseq_pkg::*;
#(
  parameter int OUT_W = 16,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dispatch,
  input  logic [1:0]       op_kind,
  input  logic [1:0]       op_len,
  input  logic             op_sign,
  input  logic             op_packed,
  input  logic [3:0]       op_n,
  input  logic [7:0]       op_a,
  input  logic [7:0]       op_b,
  input  logic             rd,
  output logic [OUT_W-1:0] rd_data,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_count,
  output logic             dsp_err
);
  localparam int LEN_W = OUT_W - 2;

  logic       jump_q, sign_q, packed_q, loaded_q, a_done_q;
  logic [1:0] len_q;
  logic [3:0] n_q;
  logic [7:0] a_q, b_q;
  step_t      step_q, step_nx;
  logic [OUT_W-1:0] item;
  logic       take;
  logic       in_jump;

  assign take    = rd && !dispatch;
  assign in_jump = (op_kind == KIND_JUMP);

  opseq_step u_step (
    .restart  (dispatch),
    .is_jump  (dispatch ? in_jump   : jump_q),
    .packed_a (dispatch ? op_packed : packed_q),
    .len      (dispatch ? op_len    : len_q),
    .n        (dispatch ? op_n      : n_q),
    .cur      (step_q),
    .nxt      (step_nx)
  );

  opseq_item_mux #(.OUT_W(OUT_W)) u_mux (
    .step   (step_q),
    .sign_a (sign_q),
    .len    (len_q),
    .n      (n_q),
    .a      (a_q),
    .b      (b_q),
    .item   (item)
  );

  opseq_rdcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (dispatch),
    .inc (take),
    .cnt (rd_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      jump_q   <= 1'b0;
      sign_q   <= 1'b0;
      packed_q <= 1'b0;
      loaded_q <= 1'b0;
      a_done_q <= 1'b0;
      len_q    <= '0;
      n_q      <= '0;
      a_q      <= '0;
      b_q      <= '0;
      step_q   <= STP_LEN;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      dsp_err  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      dsp_err  <= 1'b0;
      if (dispatch) begin
        dsp_err  <= loaded_q && !jump_q && (len_q == LEN_LONG) && !a_done_q;
        jump_q   <= in_jump;
        sign_q   <= op_sign;
        packed_q <= op_packed;
        len_q    <= op_len;
        n_q      <= op_n;
        a_q      <= op_a;
        b_q      <= op_b;
        loaded_q <= 1'b1;
        a_done_q <= 1'b0;
        step_q   <= step_nx;
      end else if (rd) begin
        rd_data  <= item;
        rd_valid <= 1'b1;
        step_q   <= step_nx;
        if (step_q == STP_A || step_q == STP_ALO) a_done_q <= 1'b1;
      end
    end
  end

  // R3
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> rd_valid);

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> !rd_valid);

  // R9
  jump_len_chk: assert property (@(posedge clk) disable iff (rst)
    (loaded_q && jump_q && take) |=> rd_data == {{LEN_W{1'b0}}, len_q});

  // R12
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    !dispatch |=> !dsp_err);

  // R6
  nibble_order_chk: assert property (@(posedge clk) disable iff (rst)
    (take && step_q == STP_AHI) |=> step_q == STP_ALO);
endmodule

// File: tb/sim_opseq_top.sv
module sim_opseq_top;
  localparam int OW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic dispatch = 1'b0, rd = 1'b0, op_sign = 1'b0, op_packed = 1'b0;
  logic [1:0] op_kind = '0, op_len = '0;
  logic [3:0] op_n = '0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [OW-1:0] rd_data;
  logic rd_valid, dsp_err;
  logic [2:0] rd_count;

  int checks = 0, fails = 0;

  typedef struct { logic [OW-1:0] val; string tag; } exp_t;
  exp_t expq[$];

  opseq_top #(.OUT_W(OW), .CNT_W(3)) u0 (
    .clk(clk), .rst(rst), .dispatch(dispatch), .op_kind(op_kind), .op_len(op_len),
    .op_sign(op_sign), .op_packed(op_packed), .op_n(op_n), .op_a(op_a), .op_b(op_b),
    .rd(rd), .rd_data(rd_data), .rd_valid(rd_valid), .rd_count(rd_count), .dsp_err(dsp_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per delivered item
  initial begin
    forever begin
      @(posedge clk); #5;
      if (rd_valid) begin
        if (expq.size() == 0) chk(1'b0, "R3", "item with nothing expected", rd_data, 0);
        else begin
          exp_t e;
          e = expq.pop_front();
          chk(rd_data == e.val, e.tag, "item", rd_data, e.val);
        end
      end
    end
  end

  // driver: dispatch an opcode, then issue reads and queue expected items
  task automatic run_op(input logic [1:0] k, input logic [1:0] l, input logic s,
                        input logic p, input logic [3:0] nn, input logic [7:0] aa,
                        input logic [7:0] bb, input int nreads, input bit exp_err);
    exp_t lst[$];
    exp_t e;
    bit reg_like;
    reg_like = (k != 2'b10);
    @(negedge clk);
    op_kind = k; op_len = l; op_sign = s; op_packed = p; op_n = nn; op_a = aa; op_b = bb;
    dispatch = 1'b1;
    @(posedge clk); #5;
    chk(dsp_err == exp_err, "R12", "error pulse", dsp_err, exp_err);
    chk(rd_count == 0, "R2", "count after dispatch", rd_count, 0);
    @(negedge clk);
    dispatch = 1'b0;
    op_a = ~aa; op_b = ~bb; op_n = ~nn; op_len = ~l; op_sign = ~s; op_packed = ~p; // R2 scramble
    if (!reg_like) begin
      e.val = OW'(l); e.tag = "R9"; lst.push_back(e);
    end else begin
      if (nn != 4'hF) begin e.val = OW'(nn); e.tag = (k == 2'b01) ? "R10" : "R4"; lst.push_back(e); end
      if (l >= 2) begin
        if (p) begin
          e.val = OW'(aa[7:4]); e.tag = "R6"; lst.push_back(e);
          e.val = OW'(aa[3:0]); e.tag = "R6"; lst.push_back(e);
        end else begin
          e.val = s ? {{8{aa[7]}}, aa} : {8'h00, aa}; e.tag = "R7"; lst.push_back(e);
        end
      end
      if (l == 2'd3) begin e.val = OW'(bb); e.tag = "R5"; lst.push_back(e); end
      e.val = OW'(l); e.tag = "R8"; lst.push_back(e);
    end
    for (int i = 0; i < nreads; i++) begin
      rd = 1'b1;
      expq.push_back(lst[(i < lst.size()) ? i : lst.size() - 1]);
      @(negedge clk);
    end
    rd = 1'b0;
    @(posedge clk); #5;
    chk(rd_count == ((nreads > 7) ? 7 : nreads), "R11", "read count", rd_count,
        (nreads > 7) ? 7 : nreads);
    chk(expq.size() == 0, "R3", "items outstanding", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(rd_valid == 0 && rd_count == 0 && dsp_err == 0, "R1", "reset outputs",
        {rd_valid, rd_count, dsp_err}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #5;
    chk(rd_valid == 0 && rd_count == 0 && dsp_err == 0, "R1", "first cycle after reset",
        {rd_valid, rd_count, dsp_err}, 0);
    @(negedge clk); rd = 1'b1;
    begin exp_t e; e.val = '0; e.tag = "R1"; expq.push_back(e); end
    @(negedge clk); rd = 1'b0;
    @(posedge clk); #5;
    chk(expq.size() == 0, "R1", "read before dispatch", expq.size(), 0);

    run_op(2'b00, 2'd1, 1'b0, 1'b0, 4'd5,  8'h00, 8'h00, 3, 1'b0); // R4 N then R8 length
    run_op(2'b00, 2'd1, 1'b0, 1'b0, 4'hF,  8'h00, 8'h00, 2, 1'b0); // R4 N skipped
    run_op(2'b00, 2'd2, 1'b1, 1'b0, 4'd3,  8'h9C, 8'h00, 3, 1'b0); // R7 sign-extend
    run_op(2'b00, 2'd2, 1'b0, 1'b0, 4'd3,  8'h9C, 8'h00, 3, 1'b0); // R7 zero-extend
    run_op(2'b00, 2'd2, 1'b1, 1'b1, 4'hF,  8'h9C, 8'h00, 3, 1'b0); // R6 packed
    run_op(2'b00, 2'd3, 1'b1, 1'b0, 4'hF,  8'h80, 8'hF1, 4, 1'b0); // R5 a then b
    run_op(2'b01, 2'd3, 1'b0, 1'b1, 4'd7,  8'h5A, 8'h33, 5, 1'b0); // R10 pause
    run_op(2'b10, 2'd2, 1'b1, 1'b0, 4'd4,  8'h12, 8'h00, 3, 1'b0); // R9 jump; R12 no error
    run_op(2'b00, 2'd1, 1'b0, 1'b0, 4'd2,  8'h00, 8'h00, 9, 1'b0); // R11 saturation
    run_op(2'b00, 2'd3, 1'b0, 1'b0, 4'd6,  8'h44, 8'h55, 1, 1'b0); // a left unread
    run_op(2'b00, 2'd1, 1'b0, 1'b0, 4'hF,  8'h00, 8'h00, 0, 1'b1); // R12 error
    run_op(2'b00, 2'd3, 1'b0, 1'b1, 4'hF,  8'h3C, 8'h00, 1, 1'b0); // only high nibble
    run_op(2'b10, 2'd1, 1'b0, 1'b0, 4'd0,  8'h00, 8'h00, 1, 1'b1); // R12 half packed
    run_op(2'b00, 2'd2, 1'b0, 1'b0, 4'd9,  8'h11, 8'h00, 0, 1'b0); // short unread
    run_op(2'b11, 2'd2, 1'b1, 1'b0, 4'd1,  8'hF0, 8'h00, 3, 1'b0); // R4 code 11 regular; R12 none

    // R2: read in the same cycle as dispatch is ignored
    @(negedge clk);
    op_kind = 2'b00; op_len = 2'd1; op_sign = 1'b0; op_packed = 1'b0; op_n = 4'd8;
    dispatch = 1'b1; rd = 1'b1;
    @(posedge clk); #5;
    chk(rd_valid == 0, "R2", "valid on dispatch read", rd_valid, 0);
    chk(rd_count == 0, "R2", "count on dispatch read", rd_count, 0);
    @(negedge clk); dispatch = 1'b0;
    begin exp_t e; e.val = OW'(8); e.tag = "R2"; expq.push_back(e); end
    @(negedge clk); rd = 1'b0;
    @(posedge clk); #5;
    chk(expq.size() == 0 && rd_count == 1, "R2", "N still first", rd_count, 1);

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule